// File: doc/BRIEF.md
# Depth-Banked Low-Power Synchronous RAM

This block presents one synchronous single-port RAM to the logic around it, but stores the data in several smaller banks that split the address range, rather than the data width. The top address bits pick one bank. Only that bank gets a clock enable on an access cycle, so the other banks stay idle and draw no access power. The read word comes back through a multiplexer whose select is captured on the read cycle.

The user's write and read enables, together with an optional user clock enable, are merged into the per-bank clock enables. When the user clock enable is present, it is ANDed in. When it is absent, the operation enable alone drives the bank clock enable. In either case, the values seen at the logical port match those of one flat RAM of the same size. A debug output exposes the per-bank clock enable vector.

Top module: `banked_ram`

## Requirements
- R1: Parameters DEPTH, WIDTH, BANKS and HAS_UCE set the logical depth, the word width, the bank count and whether the uce input is used. The default is 4096 words of 4 bits in 4 banks with uce used. Every logical address holds its own word. Elaboration fails when BANKS is not 2 or 4, or when DEPTH is not a power of two that divides evenly among the banks.
- R2: At most one bit of bank_ce_dbg is set in any cycle. On an access cycle, the set bit is the one whose index equals the top log2(BANKS) address bits. Bit i thus covers addresses i*DEPTH/BANKS up to (i+1)*DEPTH/BANKS-1.
- R3: A rising edge with we=1 and the access enabled stores wdata at addr.
- R4: A rising edge with re=1 and the access enabled puts the word at addr on rdata after that edge, with one cycle of latency. If we is also set in that cycle, the old word is returned.
- R5: rdata keeps its value after any edge without an enabled read, including write-only and idle cycles.
- R6: With HAS_UCE=1, uce=0 blocks the whole access: bank_ce_dbg stays 0, no word is written and rdata does not change. With HAS_UCE=0, the uce input has no effect, and we or re alone drives the bank clock enable.
- R7: While rst_n is low, and after reset until the first read, rdata is 0. With no access requested, bank_ce_dbg is 0.
- R8: For any mix of reads and writes, rdata matches a single flat RAM of DEPTH words driven with the same sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset for the read path registers |
| addr | input | $clog2(DEPTH) | Logical word address |
| wdata | input | WIDTH | Write word |
| we | input | 1 | Write enable |
| re | input | 1 | Read enable |
| uce | input | 1 | User clock enable (ignored when HAS_UCE=0) |
| rdata | output | WIDTH | Read word, one cycle after the read |
| bank_ce_dbg | output | BANKS | Per-bank clock enables of the current cycle |

## Verification
The assertions assume that addr, we, re and uce are settled well before each rising edge. They also assume that uce is only relevant when HAS_UCE is set. The bench meets this by changing every input on the falling edge. It fills the whole address range first, so no read returns a word that was never written. The random phase draws addresses from the full range and mixes in cycles with both enables set and with uce low. Directed cases hit the first and last word of every bank.

// File: rtl/banked_ram.sv
module banked_ram #(
  parameter int DEPTH   = 4096,
  parameter int WIDTH   = 4,
  parameter int BANKS   = 4,
  parameter bit HAS_UCE = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [$clog2(DEPTH)-1:0] addr,
  input  logic [WIDTH-1:0]         wdata,
  input  logic                     we,
  input  logic                     re,
  input  logic                     uce,
  output logic [WIDTH-1:0]         rdata,
  output logic [BANKS-1:0]         bank_ce_dbg
);
  localparam int AW = $clog2(DEPTH);
  localparam int SW = $clog2(BANKS);
  localparam int LW = AW - SW;
  localparam int BD = DEPTH / BANKS;

  // R1
  if ((BANKS != 2 && BANKS != 4) || DEPTH != (1 << AW) || DEPTH % BANKS != 0) begin : g_bad_cfg
    $error("banked_ram: unsupported DEPTH/BANKS combination");
  end

  logic                       user_on;
  logic [SW-1:0]              bsel;
  logic [LW-1:0]              laddr;
  logic [SW-1:0]              sel_q;
  logic [BANKS-1:0]           bank_ce;
  logic [BANKS-1:0][WIDTH-1:0] bank_rd;

  assign user_on = HAS_UCE ? uce : 1'b1;
  assign bsel    = addr[AW-1 -: SW];
  assign laddr   = addr[LW-1:0];

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [WIDTH-1:0] mem [BD];
    logic [WIDTH-1:0] q;

    assign bank_ce[b] = (bsel == SW'(b)) & (we | re) & user_on;

    always_ff @(posedge clk)
      if (bank_ce[b] && we) mem[laddr] <= wdata;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                 q <= '0;
      else if (bank_ce[b] && re)  q <= mem[laddr];

    assign bank_rd[b] = q;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)             sel_q <= '0;
    else if (re && user_on) sel_q <= bsel;

  assign rdata       = bank_rd[sel_q];
  assign bank_ce_dbg = bank_ce;

  // R2
  one_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_ce_dbg));

  // R2
  decode_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_ce_dbg != '0) |-> bank_ce_dbg[addr[AW-1 -: SW]]);

  // R5
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(re && (uce || !HAS_UCE)) |=> $stable(rdata));

  // R6
  uce_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (HAS_UCE && !uce) |-> (bank_ce_dbg == '0));

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(we || re) |-> (bank_ce_dbg == '0));
endmodule

// File: tb/tb_banked_ram.sv
module tb_banked_ram;
  localparam int DEPTH = 4096, WIDTH = 4, BANKS = 4, BD = DEPTH / BANKS;
  localparam int D2 = 256, B2 = 2, BD2 = D2 / B2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic [7:0]  addr2 = '0;
  logic [3:0]  wdata = '0;
  logic we = 1'b0, re = 1'b0, uce = 1'b0;
  logic [3:0] rdata, rdata2;
  logic [3:0] ce;
  logic [1:0] ce2;

  int total = 0, bad = 0;
  bit done = 1'b0;
  logic [3:0] mem [DEPTH];
  logic [3:0] mem2 [D2];
  logic [3:0] exp_rd = '0, exp_rd2 = '0;

  always #5 clk = ~clk;

  banked_ram #(.DEPTH(DEPTH), .WIDTH(WIDTH), .BANKS(BANKS), .HAS_UCE(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .we(we), .re(re),
    .uce(uce), .rdata(rdata), .bank_ce_dbg(ce));

  banked_ram #(.DEPTH(D2), .WIDTH(WIDTH), .BANKS(B2), .HAS_UCE(1'b0)) dut_nce (
    .clk(clk), .rst_n(rst_n), .addr(addr2), .wdata(wdata), .we(we), .re(re),
    .uce(1'b0), .rdata(rdata2), .bank_ce_dbg(ce2));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_ce(input logic [11:0] a, input bit w, input bit r, input bit u);
    return (w | r) & u ? 4'(1 << (a / BD)) : 4'b0;
  endfunction

  function automatic logic [1:0] exp_ce2(input logic [7:0] a, input bit w, input bit r);
    return (w | r) ? 2'(1 << (a / BD2)) : 2'b0;
  endfunction

  task automatic cyc(input logic [11:0] a, input logic [3:0] d, input bit w, input bit r,
                     input bit u, input string req);
    @(negedge clk);
    addr = a; addr2 = a[7:0]; wdata = d; we = w; re = r; uce = u;
    #1;
    chk(ce == exp_ce(a, w, r, u), "R2 bank_ce", ce, exp_ce(a, w, r, u));
    chk(ce2 == exp_ce2(a[7:0], w, r), "R6 nce bank_ce", ce2, exp_ce2(a[7:0], w, r));
    @(posedge clk);
    if (r && u) exp_rd = mem[a];
    if (w && u) mem[a] = d;
    if (r) exp_rd2 = mem2[a[7:0]];
    if (w) mem2[a[7:0]] = d;
    #1;
    chk(rdata == exp_rd, req, rdata, exp_rd);
    chk(rdata2 == exp_rd2, {req, " nce"}, rdata2, exp_rd2);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    chk(rdata == 4'h0, "R7 rdata in reset", rdata, 0);
    chk(ce == 4'h0, "R7 ce idle in reset", ce, 0);
    @(negedge clk) rst_n = 1'b1;
    // R1 / R3: fill every address
    for (int i = 0; i < DEPTH; i++) cyc(12'(i), 4'(i ^ (i >> 4) ^ (i >> 8)), 1'b1, 1'b0, 1'b1, "R3 fill");
    chk(rdata == 4'h0, "R7 rdata before first read", rdata, 0);
    // R1 / R4: read back full range
    for (int i = 0; i < DEPTH; i++) cyc(12'(i), 4'h0, 1'b0, 1'b1, 1'b1, "R1 readback");
    // R2 / R4: bank edges
    for (int b = 0; b < BANKS; b++) begin
      cyc(12'(b * BD), 4'h0, 1'b0, 1'b1, 1'b1, "R2 bank first");
      cyc(12'(b * BD + BD - 1), 4'h0, 1'b0, 1'b1, 1'b1, "R2 bank last");
    end
    // R4: read-old on simultaneous write
    cyc(12'd1500, 4'hA, 1'b1, 1'b1, 1'b1, "R4 read-first");
    cyc(12'd1500, 4'h0, 1'b0, 1'b1, 1'b1, "R4 new value");
    // R5: write and idle cycles hold rdata
    cyc(12'd3000, 4'h5, 1'b1, 1'b0, 1'b1, "R5 hold on write");
    cyc(12'd10, 4'h0, 1'b0, 1'b0, 1'b1, "R5 hold on idle");
    // R6: uce low blocks write and read
    cyc(12'd4095, 4'h3, 1'b1, 1'b1, 1'b0, "R6 uce low blocks");
    cyc(12'd4095, 4'h0, 1'b0, 1'b1, 1'b1, "R6 no write under uce low");
    // R8: random mix
    for (int k = 0; k < 6000; k++) begin
      int unsigned rv = $urandom;
      cyc(12'($urandom % DEPTH), 4'($urandom), rv[0], rv[1], (rv[4:2] != 3'd0), "R8 random");
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule